// File: doc/BRIEF.md
# Strobe-Framed Serial Register Port

This block is the device side of a three-wire serial register port: a serial clock, a serial data input and a serial data output, plus a separate active-low strobe line. The host shifts a command into the device. Each rising edge of the serial clock with the strobe high moves one bit in. A single serial clock with the strobe low closes the frame. During that closing clock the level of the data input selects the operation: high commits a write, low starts a read. Every field moves most significant bit first.

A write frame carries the data word first and the 8-bit address last. A read frame carries only the 8-bit address. After the read strobe the device drives the addressed word out over the next `DATA_W` serial clocks. The register map holds five locations:

- a control word at 0x00;
- a routing word at 0x02;
- a read-only switch bank at 0x08;
- a sticky reset-request bit at 0x80;
- a read-only build-identifier constant at 0xFF.

The serial lines and the switch inputs are oversampled by the system clock through synchronizer chains. Serial clock edges are detected from the synchronized copy.

The sequencer has three states:

- `ST_COLLECT`: shifts input bits and watches for the strobe.
- `ST_ARM`: entered on a read strobe. The MSB of the word is already on the output and the device waits for the first read clock.
- `ST_SEND`: counts read clocks and shifts on falling edges.

The transitions are:

- `ST_COLLECT` to `ST_ARM` on a rising edge with the strobe low and the data input low.
- `ST_ARM` to `ST_SEND` on the next rising edge.
- `ST_SEND` to `ST_COLLECT` on the falling edge after the last read clock.

A write strobe (strobe low, data high) commits without leaving `ST_COLLECT`.

Top module: `srp_top`

## Requirements
- R1: While `rst_n` is low and right after it is released, `mode_o`, `mux_o`, `rst_req_o` and `ser_dout_o` are all 0.
- R2: A write frame commits on its strobe clock. The frame is 32 data bits, then 8 address bits, both MSB first, then one strobe clock with the data input high. Address 0x00 loads the full word into `mode_o`, and reading 0x00 returns it.
- R3: Address 0x02 is a separate read/write word driven on `mux_o`. Writing it leaves the 0x00 word unchanged.
- R4: A read frame is 8 address bits, then one strobe clock with the data input low. The addressed word then appears on `ser_dout_o`, MSB first. Each bit is valid while the serial clock is high, and the device advances to the next bit only on falling edges of the serial clock.
- R5: Address 0x08 reads the synchronized `sw_bank_i` value in its low bits, with zeros above. Writes to 0x08 change nothing.
- R6: Address 0xFF reads the `VERSION` parameter. Writes to 0xFF change nothing.
- R7: A write to 0x80 with data bit 0 set raises `rst_req_o`. A write with bit 0 clear does not lower it; only `rst_n` does. Reading 0x80 returns the request in bit 0.
- R8: Writes to any other address change no register, and reads of any other address return zero.
- R9: Only the most recent bits shifted before the strobe form the frame: the last 40 for a write, the last 8 for a read. Any earlier bits are discarded.
- R10: After the last read clock, `ser_dout_o` returns low and the next frame is accepted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_stb_n_i | input | 1 | Active-low frame strobe, idles high |
| ser_din_i | input | 1 | Serial data from the host |
| ser_dout_o | output | 1 | Serial read data to the host |
| sw_bank_i | input | SW_W | Asynchronous switch-bank inputs |
| mode_o | output | DATA_W | Control word register (0x00) |
| mux_o | output | DATA_W | Routing word register (0x02) |
| rst_req_o | output | 1 | Sticky system-reset request |

## Verification
The bench builds the block with a 6-bit switch bank, so reads of 0x08 show that the bits above the bank come back as zero. It uses a non-default build identifier, so the 0xFF read cannot pass by matching a default. It also uses three synchronizer stages, which adds latency between each serial edge and the output. With this latency the bench checks that the MSB still appears before the first read clock and that each later bit settles before the rising edge that samples it. The 32-bit data width keeps the full write frame at 40 bits, so preceding a frame with stray bits shows that only the last 40 (write) or 8 (read) bits are used.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] REG_MODE  = 8'h00;
    localparam logic [ADDR_W-1:0] REG_MUX   = 8'h02;
    localparam logic [ADDR_W-1:0] REG_SW    = 8'h08;
    localparam logic [ADDR_W-1:0] REG_RESET = 8'h80;
    localparam logic [ADDR_W-1:0] REG_VER   = 8'hFF;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_ARM     = 2'd1,
        ST_SEND    = 2'd2
    } srp_state_e;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= RST_VAL;
        end else begin
            chain[0] <= d;
        end
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else begin
                    chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/srp_frame.sv
module srp_frame
    import srp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              stb_n_s,
    input  logic              din_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic              rd_load,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              dout
);

    localparam int FRAME_W = DATA_W + ADDR_W;
    localparam int CNT_W   = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

    srp_state_e state, state_nxt;

    logic               sclk_q;
    logic               rise, fall;
    logic [FRAME_W-1:0] shift_in;
    logic [DATA_W-1:0]  out_sr;
    logic [CNT_W-1:0]   bit_cnt;
    logic               strobe_edge;

    assign rise        = sclk_s & ~sclk_q;
    assign fall        = ~sclk_s & sclk_q;
    assign strobe_edge = (state == ST_COLLECT) & rise & ~stb_n_s;

    assign wr_en    = strobe_edge & din_s;
    assign rd_load  = strobe_edge & ~din_s;
    assign reg_addr = shift_in[ADDR_W-1:0];
    assign wr_data  = shift_in[FRAME_W-1:ADDR_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
        end else begin
            state <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_COLLECT: begin
                if (rd_load) begin
                    state_nxt = ST_ARM;
                end
            end
            ST_ARM: begin
                if (rise) begin
                    state_nxt = ST_SEND;
                end
            end
            ST_SEND: begin
                if (fall && bit_cnt == LAST_CNT) begin
                    state_nxt = ST_COLLECT;
                end
            end
            default: state_nxt = ST_COLLECT;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            shift_in <= '0;
            out_sr   <= '0;
            bit_cnt  <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (state == ST_COLLECT && rise && stb_n_s) begin
                shift_in <= {shift_in[FRAME_W-2:0], din_s};
            end
            if (rd_load) begin
                out_sr  <= rd_data;
                bit_cnt <= '0;
            end else if (state == ST_ARM) begin
                if (rise) begin
                    bit_cnt <= CNT_W'(1);
                end
            end else if (state == ST_SEND) begin
                if (rise) begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
                if (fall && bit_cnt != LAST_CNT) begin
                    out_sr <= {out_sr[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign dout = (state != ST_COLLECT) & out_sr[DATA_W-1];

endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
    import srp_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter int                SW_W    = 8,
    parameter logic [DATA_W-1:0] VERSION = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SW_W-1:0]   sw_s,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] mux_q,
    output logic              req_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            mux_q  <= '0;
            req_q  <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr)
                REG_MODE:  mode_q <= wr_data;
                REG_MUX:   mux_q  <= wr_data;
                REG_RESET: begin
                    if (wr_data[0]) begin
                        req_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr)
            REG_MODE:  rd_data = mode_q;
            REG_MUX:   rd_data = mux_q;
            REG_SW:    rd_data[SW_W-1:0] = sw_s;
            REG_RESET: rd_data[0] = req_q;
            REG_VER:   rd_data = VERSION;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/srp_top.sv
module srp_top
    import srp_pkg::*;
#(
    parameter int                DATA_W      = 32,
    parameter int                SW_W        = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] VERSION     = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_stb_n_i,
    input  logic              ser_din_i,
    output logic              ser_dout_o,
    input  logic [SW_W-1:0]   sw_bank_i,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] mux_o,
    output logic              rst_req_o
);

    logic [2:0]        line_s;
    logic [SW_W-1:0]   sw_s;
    logic              wr_en;
    logic              rd_load;
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    // order: {serial clock, strobe, data in}; strobe resets to idle high
    srp_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_line_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk_i, ser_stb_n_i, ser_din_i}),
        .q     (line_s)
    );

    srp_sync #(
        .W       (SW_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('0)
    ) u_sw_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sw_bank_i),
        .q     (sw_s)
    );

    srp_frame #(
        .DATA_W (DATA_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (line_s[2]),
        .stb_n_s  (line_s[1]),
        .din_s    (line_s[0]),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .rd_load  (rd_load),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .dout     (ser_dout_o)
    );

    srp_regfile #(
        .DATA_W  (DATA_W),
        .SW_W    (SW_W),
        .VERSION (VERSION)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .sw_s     (sw_s),
        .rd_data  (rd_data),
        .mode_q   (mode_o),
        .mux_q    (mux_o),
        .req_q    (rst_req_o)
    );

endmodule

// File: rtl/srp_chk.sv
module srp_chk
    import srp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_load,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] mode_o,
    input logic [DATA_W-1:0] mux_o,
    input logic              rst_req_o,
    input logic              ser_dout_o
);

    // R2
    mode_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> $past(wr_en && reg_addr == REG_MODE));

    // R3
    mux_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mux_o) |-> $past(wr_en && reg_addr == REG_MUX));

    // R7
    req_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(wr_en && reg_addr == REG_RESET && wr_data[0]));

    // R7
    req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(rst_req_o));

    // R4
    dout_msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_load |=> (ser_dout_o == $past(rd_data[DATA_W-1])));

    // R4
    single_command_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, rd_load}));

endmodule

bind srp_top srp_chk #(.DATA_W(DATA_W)) u_srp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_load    (rd_load),
    .reg_addr   (reg_addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .mode_o     (mode_o),
    .mux_o      (mux_o),
    .rst_req_o  (rst_req_o),
    .ser_dout_o (ser_dout_o)
);

// File: tb/srp_top_bench.sv
module srp_top_bench;

    localparam int          SW_W = 6;
    localparam logic [31:0] VER  = 32'h1234_ABCD;
    localparam logic [5:0]  SW   = 6'h2D;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    // writes: data is the value sent; reads: data is the expected result
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'h00, 32'hDEAD_BEEF, 4'd2},  // R2 write control word
        '{1'b0, 8'h00, 32'hDEAD_BEEF, 4'd2},  // R2 read back
        '{1'b1, 8'h02, 32'h0F0F_1234, 4'd3},  // R3 write routing word
        '{1'b0, 8'h02, 32'h0F0F_1234, 4'd3},  // R3 read back
        '{1'b0, 8'h00, 32'hDEAD_BEEF, 4'd3},  // R3 control word untouched
        '{1'b1, 8'h08, 32'hFFFF_FFFF, 4'd5},  // R5 write ignored
        '{1'b0, 8'h08, 32'h0000_002D, 4'd5},  // R5 zero-extended switches
        '{1'b1, 8'hFF, 32'h0000_0000, 4'd6},  // R6 write ignored
        '{1'b0, 8'hFF, 32'h1234_ABCD, 4'd6},  // R6 constant
        '{1'b1, 8'h55, 32'hAAAA_AAAA, 4'd8},  // R8 unmapped write
        '{1'b0, 8'h55, 32'h0000_0000, 4'd8},  // R8 unmapped read
        '{1'b0, 8'h01, 32'h0000_0000, 4'd8}   // R8 neighbour of mapped word
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sclk = 1'b0;
    logic            stb_n = 1'b1;
    logic            din = 1'b0;
    logic [SW_W-1:0] sw = SW;
    logic            dout;
    logic [31:0]     mode, mux;
    logic            rst_req;

    int errors = 0;
    int checks = 0;

    always #10ns clk = ~clk;

    srp_top #(
        .DATA_W      (32),
        .SW_W        (SW_W),
        .SYNC_STAGES (3),
        .VERSION     (VER)
    ) u_srp_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk_i   (sclk),
        .ser_stb_n_i (stb_n),
        .ser_din_i   (din),
        .ser_dout_o  (dout),
        .sw_bank_i   (sw),
        .mode_o      (mode),
        .mux_o       (mux),
        .rst_req_o   (rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        din = b;
        #200ns sclk = 1'b1;
        #200ns sclk = 1'b0;
    endtask

    task automatic strobe(input logic b);
        din   = b;
        stb_n = 1'b0;
        #200ns sclk = 1'b1;
        #200ns sclk = 1'b0;
        stb_n = 1'b1;
        din   = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        for (int i = 31; i >= 0; i--) send_bit(d[i]);
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
        strobe(1'b1);
        #400ns;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        d = '0;
        for (int i = 7; i >= 0; i--) send_bit(a[i]);
        strobe(1'b0);
        for (int i = 0; i < 32; i++) begin
            #200ns sclk = 1'b1;
            #100ns d = {d[30:0], dout};
            #100ns sclk = 1'b0;
        end
        #400ns;
        check("R10 dout idle after read", {31'b0, dout}, 32'h0);
    endtask

    initial begin
        #3ms;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        #200ns;
        // R1 during reset
        check("R1 mode in reset", mode, 32'h0);
        check("R1 req in reset", {31'b0, rst_req}, 32'h0);
        rst_n = 1'b1;
        #200ns;
        check("R1 mux after reset", mux, 32'h0);
        check("R1 dout after reset", {31'b0, dout}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k].wr) begin
                do_write(VEC[k].addr, VEC[k].data);
            end else begin
                do_read(VEC[k].addr, rd);
                check($sformatf("R%0d read %h", VEC[k].req, VEC[k].addr), rd, VEC[k].data);
            end
        end
        check("R2 mode_o port", mode, 32'hDEAD_BEEF);
        check("R3 mux_o port", mux, 32'h0F0F_1234);
        check("R8 req untouched", {31'b0, rst_req}, 32'h0);

        // R9: stray leading bits ahead of a read and a write
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        do_read(8'h02, rd);
        check("R9 read after stray bits", rd, 32'h0F0F_1234);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        do_write(8'h00, 32'h1357_9BDF);
        check("R9 write after stray bits", mode, 32'h1357_9BDF);

        // R7: reset request
        do_write(8'h80, 32'hFFFF_FFFE);
        check("R7 bit0 clear does not set", {31'b0, rst_req}, 32'h0);
        do_write(8'h80, 32'h0000_0001);
        check("R7 request raised", {31'b0, rst_req}, 32'h1);
        do_read(8'h80, rd);
        check("R7 read back", rd, 32'h1);
        do_write(8'h80, 32'h0000_0000);
        check("R7 sticky", {31'b0, rst_req}, 32'h1);
        rst_n = 1'b0;
        #100ns;
        check("R7 cleared by reset", {31'b0, rst_req}, 32'h0);
        check("R1 mode cleared", mode, 32'h0);
        rst_n = 1'b1;
        #200ns;

        // R4: alternating pattern after reset, and an all-ones word
        do_write(8'h02, 32'hA5A5_5A5A);
        do_read(8'h02, rd);
        check("R4 alternating pattern", rd, 32'hA5A5_5A5A);
        do_write(8'h00, 32'hFFFF_FFFF);
        do_read(8'h00, rd);
        check("R4 all ones", rd, 32'hFFFF_FFFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule